// File: doc/BRIEF.md
# Shift, Rotate and Bit-Manipulation Unit

This is a purely combinational datapath slice for an 8-bit processor core. It takes one operand byte, the current carry flag, a bit index and an operation code. In the same cycle it returns the transformed byte, a write-enable telling the register file whether to store that byte, four candidate flag values and a mask that says which flags the core should update.

The unit covers four groups of work. The first is rotates, either through carry or circular. The second is shifts: arithmetic left, and arithmetic or logical right. The third is a nibble exchange. The fourth is single-bit operations: test, clear and set. A separate short-form input selects the accumulator-only rotate variant, which always clears Z. Decoding the instruction stream and any memory access are handled elsewhere.

There are no states and no transitions. The unit has no clock and holds no state, so every output is a function of the present inputs only.

Top module: `shb_bitop_unit`

## Requirements
- R1: Operation code 0 rotates left through carry: the result is {val[6:0], cy} and carry-out is val[7]. Code 1 rotates right through carry: the result is {cy, val[7:1]} and carry-out is val[0].
- R2: Code 2 rotates left circularly, putting val[7] into result bit 0 and into carry-out. Code 3 rotates right circularly, putting val[0] into result bit 7 and into carry-out.
- R3: Code 4 shifts left arithmetically: the result is {val[6:0], 0} and carry-out is val[7].
- R4: Code 5 shifts right arithmetically, keeping val[7] in bit 7. Code 6 shifts right logically, putting 0 into bit 7. Both take carry-out from val[0].
- R5: For codes 0 to 6, flags_o (bit 3 Z, bit 2 N, bit 1 H, bit 0 C) gives Z as (result == 0), N = 0, H = 0 and C = carry-out. flag_mask_o is 4'b1111.
- R6: With short_i high, codes 0 to 3 give Z = 0 whatever the result is. For every other code, short_i has no effect on any output.
- R7: Code 7 exchanges the two nibbles. Z is (result == 0), N, H and C are 0, and the mask is 4'b1111.
- R8: Code 8 tests bit idx_i: Z = 1 when that bit is 0, N = 0, H = 1, and the mask is 4'b1110 so C is left untouched. The result equals val_i and wr_en_o is 0.
- R9: Code 9 clears bit idx_i and code 10 sets bit idx_i, where index 0 is the least significant bit. Both give flag_mask_o = 0.
- R10: wr_en_o is 1 for codes 0 to 7, 9 and 10, and 0 for code 8.
- R11: Codes 11 to 15 pass val_i through with wr_en_o = 0 and flag_mask_o = 0. In every case, any flags_o bit whose mask bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (0 to 10 defined) |
| val_i | input | 8 | Operand byte |
| cy_i | input | 1 | Incoming carry flag |
| idx_i | input | 3 | Bit index for test, clear and set |
| short_i | input | 1 | Accumulator short-form rotate mode |
| res_o | output | 8 | Resulting byte |
| wr_en_o | output | 1 | Store the result |
| flags_o | output | 4 | New Z, N, H, C (bits 3..0) |
| flag_mask_o | output | 4 | Flags to update (bits 3..0) |

## Verification
The bench builds the unit with its default 8-bit width, which gives a 3-bit index. At that size the whole input space fits in the run: all 16 operation codes, both carry values, both short-form settings, all 8 indices and all 256 operand values, each compared against a behavioural model. This exhaustive sweep reaches every edge bit moving into carry, every zero result, every short-form override and each undefined code.

// File: rtl/shb_pkg.sv
package shb_pkg;

    typedef enum logic [3:0] {
        OP_ROL_CY   = 4'd0,
        OP_ROR_CY   = 4'd1,
        OP_ROL_CIRC = 4'd2,
        OP_ROR_CIRC = 4'd3,
        OP_SHL_A    = 4'd4,
        OP_SHR_A    = 4'd5,
        OP_SHR_L    = 4'd6,
        OP_NIB_SWAP = 4'd7,
        OP_BIT_TEST = 4'd8,
        OP_BIT_CLR  = 4'd9,
        OP_BIT_SET  = 4'd10
    } shb_op_e;

    localparam int FLG_Z = 3;
    localparam int FLG_N = 2;
    localparam int FLG_H = 1;
    localparam int FLG_C = 0;

endpackage

// File: rtl/shb_shift_core.sv
module shb_shift_core
    import shb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o,
    output logic              hit_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    always_comb begin
        res_o  = val_i;
        cout_o = 1'b0;
        hit_o  = 1'b1;
        case (shb_op_e'(op_i))
            OP_ROL_CY: begin
                res_o  = {val_i[MSB-1:0], cy_i};
                cout_o = val_i[MSB];
            end
            OP_ROR_CY: begin
                res_o  = {cy_i, val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_ROL_CIRC: begin
                res_o  = {val_i[MSB-1:0], val_i[MSB]};
                cout_o = val_i[MSB];
            end
            OP_ROR_CIRC: begin
                res_o  = {val_i[0], val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_SHL_A: begin
                res_o  = {val_i[MSB-1:0], 1'b0};
                cout_o = val_i[MSB];
            end
            OP_SHR_A: begin
                res_o  = {val_i[MSB], val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_SHR_L: begin
                res_o  = {1'b0, val_i[MSB:1]};
                cout_o = val_i[0];
            end
            OP_NIB_SWAP: begin
                res_o  = {val_i[HALF_W-1:0], val_i[MSB:HALF_W]};
                cout_o = 1'b0;
            end
            default: hit_o = 1'b0;
        endcase
    end

    // R7: the exchanged value must hold the old low nibble on top
    always_comb begin
        if (op_i == OP_NIB_SWAP) begin
            p_swap_upper_r7: assert (res_o[MSB:HALF_W] == val_i[HALF_W-1:0] && !cout_o);
        end
    end

endmodule

// File: rtl/shb_bit_core.sv
module shb_bit_core
    import shb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = $clog2(DATA_W)
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] res_o,
    output logic              picked_o,
    output logic              hit_o
);
    logic [DATA_W-1:0] sel;

    for (genvar g = 0; g < DATA_W; g++) begin : g_sel
        assign sel[g] = (idx_i == IDX_W'(g));
    end

    assign picked_o = |(val_i & sel);

    always_comb begin
        res_o = val_i;
        hit_o = 1'b1;
        case (shb_op_e'(op_i))
            OP_BIT_TEST: res_o = val_i;
            OP_BIT_CLR:  res_o = val_i & ~sel;
            OP_BIT_SET:  res_o = val_i | sel;
            default:     hit_o = 1'b0;
        endcase
    end

    // R9: exactly one bit position is selected by the index
    always_comb begin
        p_sel_onehot_r9: assert ($countones(sel) == 1);
    end

endmodule

// File: rtl/shb_bitop_unit.sv
module shb_bitop_unit
    import shb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic              cy_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              short_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_en_o,
    output logic [3:0]        flags_o,
    output logic [3:0]        flag_mask_o
);
    logic [DATA_W-1:0] s_res, b_res;
    logic              s_cout, s_hit, b_pick, b_hit;
    logic              is_rot;

    shb_shift_core #(.DATA_W(DATA_W)) u_shift (
        .op_i   (op_i),
        .val_i  (val_i),
        .cy_i   (cy_i),
        .res_o  (s_res),
        .cout_o (s_cout),
        .hit_o  (s_hit)
    );

    shb_bit_core #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bit (
        .op_i     (op_i),
        .val_i    (val_i),
        .idx_i    (idx_i),
        .res_o    (b_res),
        .picked_o (b_pick),
        .hit_o    (b_hit)
    );

    assign is_rot = (op_i <= OP_ROR_CIRC);

    always_comb begin
        res_o       = val_i;
        wr_en_o     = 1'b0;
        flags_o     = 4'b0000;
        flag_mask_o = 4'b0000;
        if (s_hit) begin
            res_o          = s_res;
            wr_en_o        = 1'b1;
            flags_o[FLG_Z] = (s_res == '0) && !(short_i && is_rot);
            flags_o[FLG_C] = s_cout;
            flag_mask_o    = 4'b1111;
        end else if (b_hit) begin
            res_o = b_res;
            if (op_i == OP_BIT_TEST) begin
                flags_o[FLG_Z] = !b_pick;
                flags_o[FLG_H] = 1'b1;
                flag_mask_o    = 4'b1110;
            end else begin
                wr_en_o = 1'b1;
            end
        end
    end

    always_comb begin
        // R11: a flag that is not to be updated is driven low
        p_masked_low_r11: assert ((flags_o & ~flag_mask_o) == 4'b0000);
        // R8: the test leaves the operand unwritten
        if (op_i == OP_BIT_TEST) begin
            p_test_nowrite_r8: assert (!wr_en_o && res_o == val_i && !flag_mask_o[FLG_C]);
        end
        // R6: short-form rotates never report zero
        if (short_i && is_rot) begin
            p_short_z_r6: assert (!flags_o[FLG_Z]);
        end
        // R5: left moves put the top operand bit into carry
        if (op_i == OP_ROL_CY || op_i == OP_ROL_CIRC || op_i == OP_SHL_A) begin
            p_left_carry_r5: assert (flags_o[FLG_C] == val_i[DATA_W-1]);
        end
    end

endmodule

// File: tb/shb_bitop_unit_tb.sv
module shb_bitop_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op;
    logic [7:0] val;
    logic       cy;
    logic [2:0] idx;
    logic       sh;
    logic [7:0] res;
    logic       wr;
    logic [3:0] flg, msk;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    shb_bitop_unit dut_i (
        .op_i        (op),
        .val_i       (val),
        .cy_i        (cy),
        .idx_i       (idx),
        .short_i     (sh),
        .res_o       (res),
        .wr_en_o     (wr),
        .flags_o     (flg),
        .flag_mask_o (msk)
    );

    function automatic string req_of(int o);
        case (o)
            0, 1:    return "R1";
            2, 3:    return "R2";
            4:       return "R3";
            5, 6:    return "R4";
            7:       return "R7";
            8:       return "R8";
            9, 10:   return "R9";
            default: return "R11";
        endcase
    endfunction

    // behavioural reference: {res, wr, Z, N, H, C, mask}
    function automatic logic [16:0] model(int o, int v, int c, int ix, int s);
        int r = v, co = 0, z = 0, h = 0, w = 0, m = 0, b;
        if (o <= 7) begin
            case (o)
                0: begin r = (v * 2 + c) % 256;        co = v / 128; end
                1: begin r = v / 2 + c * 128;          co = v % 2;   end
                2: begin r = (v * 2) % 256 + v / 128;  co = v / 128; end
                3: begin r = v / 2 + (v % 2) * 128;    co = v % 2;   end
                4: begin r = (v * 2) % 256;            co = v / 128; end
                5: begin r = v / 2 + (v / 128) * 128;  co = v % 2;   end
                6: begin r = v / 2;                    co = v % 2;   end
                default: begin r = (v % 16) * 16 + v / 16; co = 0;  end
            endcase
            z = (r == 0 && !(s == 1 && o <= 3)) ? 1 : 0;   // R5, R6
            w = 1; m = 15;
        end else if (o == 8) begin
            b = (v >> ix) % 2;
            z = 1 - b; h = 1; m = 14; co = 0;
        end else if (o == 9) begin
            r = v & ~(1 << ix) & 255; w = 1;
        end else if (o == 10) begin
            r = v | (1 << ix); w = 1;
        end
        return {r[7:0], w[0], z[0], 1'b0, h[0], co[0], m[3:0]};
    endfunction

    task automatic compare(int o, int v, int c, int ix, int s);
        logic [16:0] exp_v, act_v;
        exp_v = model(o, v, c, ix, s);
        act_v = {res, wr, flg, msk};
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s (R10 wr, R5 flags) op=%0d v=%02h cy=%0d idx=%0d short=%0d actual=%05h expected=%05h",
                     req_of(o), o, v, c, ix, s, act_v, exp_v);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 199000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        op = 4'd0; val = 8'd0; cy = 1'b0; idx = 3'd0; sh = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare(0, 0, 0, 0, 0);   // initial state, R5 zero result
        for (int o = 0; o < 16; o++)
            for (int s = 0; s < 2; s++)
                for (int c = 0; c < 2; c++)
                    for (int ix = 0; ix < 8; ix++)
                        for (int v = 0; v < 256; v++) begin
                            @(posedge clk);
                            op = o[3:0]; val = v[7:0]; cy = c[0]; idx = ix[2:0]; sh = s[0];
                            @(negedge clk);
                            compare(o, v, c, ix, s);
                        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule